// File: doc/BRIEF.md
# Page-Wide Hamming ECC Engine

This block watches the data strobes of a NAND flash stream, 8 or 16 bits wide. It builds one Hamming-style error-correcting code over the data part of a whole page. While a page is being programmed, the running code appears on two 16-bit outputs: a parity word and a complementary parity word. Together they make the four ECC bytes that software writes into the spare area.

When a page is read back, the stored ECC bytes are streamed straight after the data. The engine then classifies the result as clean, a single flipped data bit, a single flipped code bit, or an uncorrectable error. For a single data flip it reports the failing word and bit. An erased page (all ones, code bytes included) shows up as a multiple error with both offset fields all ones, so software can tell it apart from a real failure.

A control-reset pulse starts every page. It also lets software throw away strobes captured before the real data, such as address cycles. The spare-area layout, the command sequencing and the repair of the buffer are left to software.

Top module: `nand_page_ecc`

## Requirements
- R1: The page size select `pageSel` picks 512, 1024, 2048 or 4096 data bytes (value 0..3), which are pages of 528, 1056, 2112 or 4224 bytes with spare. The first N data strobes after a control reset are page data, where N is that byte count in 8-bit mode and half of it in 16-bit mode. The strobes that follow are stored-code strobes.
- R2: For each set data bit, the 16-bit address {word index[11:0], bit index[3:0]} is XORed into `parityOut` and its inverse into `nparityOut`. The result is visible after the clock edge that takes the strobe, until the last code strobe.
- R3: A `ctrlRst` pulse clears both accumulators, the stored code, the strobe counters and all flags by the next clock edge.
- R4: Stored code order is fixed. In 8-bit mode, four strobes on dataIn[7:0] carry parity[7:0], parity[15:8], nparity[7:0] and nparity[15:8]. In 16-bit mode, two strobes carry parity and then nparity.
- R5: If the stored code matches the recomputed one, all three flags stay 0 and both outputs read 0 after the last code strobe.
- R6: A single flipped data bit sets `recErr` only, and `parityOut` then reports {word[11:0], bit[3:0]} of that bit.
- R7: A single flipped bit in the stored code sets `recErr` and `eccErr`, and clears `mulErr`.
- R8: Any other mismatch sets `recErr` and `mulErr`. An all-ones page with all-ones code gives `mulErr` with `parityOut` = 16'hFFFF.
- R9: The flags read 0 until the edge that takes the last code strobe, and they are valid right after that edge.
- R10: Strobes after the last code strobe are ignored until the next `ctrlRst`, so the outputs and flags hold.
- R11: With `bus16` = 1, the word index counts 16-bit words and the bit index spans 0..15. With `bus16` = 0, only dataIn[7:0] is used and the bit index spans 0..7.
- R12: `eccErr` and `mulErr` are never set together, and either one implies `recErr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| bus16 | input | 1 | 1 selects a 16-bit stream |
| pageSel | input | 2 | Page size select (0..3) |
| ctrlRst | input | 1 | Control-reset pulse, starts a page |
| strobe | input | 1 | Data strobe, one per bus word |
| dataIn | input | 16 | Bus word, low byte in 8-bit mode |
| parityOut | output | 16 | Running parity, or data syndrome when done |
| nparityOut | output | 16 | Running complementary parity, or its syndrome |
| recErr | output | 1 | Any mismatch after the code is in |
| eccErr | output | 1 | Single flip inside the stored code |
| mulErr | output | 1 | Uncorrectable mismatch or erased page |

## Verification
Every result sits in a register one edge away from its stimulus. A strobe or control reset is driven at a falling edge and takes effect at the next rising edge. The bench drives inputs at falling edges and reads results at the falling edge after the strobe line drops, so each check sees the state one rising edge after the last stimulus. That single-edge spacing is also how the flags are shown to stay low before the final code strobe and to appear right after it. The same spacing shows that a strobe sent after completion leaves the outputs untouched.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int DATA_W = 16;
  localparam int WORD_W = 12;
  localparam int BIT_W  = 4;
  localparam int ECC_W  = WORD_W + BIT_W;
  localparam int BASE_BYTES = 512;

  typedef enum logic [1:0] {PH_DATA, PH_CODE, PH_DONE} phase_t;

  typedef struct packed {
    logic              clr;
    logic              accEn;
    logic              eccEn;
    logic [1:0]        eccIdx;
    logic [WORD_W-1:0] wordIdx;
    logic              done;
  } ecc_strobe_t;
endpackage

// File: rtl/nand_ecc_ctrl.sv
module nand_ecc_ctrl
  import nand_ecc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        bus16,
  input  logic [1:0]  pageSel,
  input  logic        ctrlRst,
  input  logic        strobe,
  output ecc_strobe_t st
);
  localparam int CNT_W = WORD_W + 1;

  phase_t            phase;
  logic [WORD_W-1:0] wordCnt;
  logic [1:0]        eccCnt;
  logic [CNT_W-1:0]  dataWords;
  logic [WORD_W-1:0] lastWord;
  logic [1:0]        lastEcc;

  always_comb begin
    dataWords = (CNT_W'(BASE_BYTES) << pageSel) >> bus16;
    lastWord  = WORD_W'(dataWords - CNT_W'(1));
    lastEcc   = bus16 ? 2'd1 : 2'd3;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_DATA;
      wordCnt <= '0;
      eccCnt  <= '0;
    end else if (ctrlRst) begin
      phase   <= PH_DATA;
      wordCnt <= '0;
      eccCnt  <= '0;
    end else if (strobe) begin
      unique case (phase)
        PH_DATA: begin
          if (wordCnt == lastWord) phase <= PH_CODE;
          else wordCnt <= wordCnt + 1'b1;
        end
        PH_CODE: begin
          if (eccCnt == lastEcc) phase <= PH_DONE;
          else eccCnt <= eccCnt + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    st.clr     = ctrlRst;
    st.accEn   = strobe && !ctrlRst && (phase == PH_DATA);
    st.eccEn   = strobe && !ctrlRst && (phase == PH_CODE);
    st.eccIdx  = eccCnt;
    st.wordIdx = wordCnt;
    st.done    = (phase == PH_DONE);
  end

  p_word_range_r1: assert property (@(posedge clk) disable iff (!rstN)
    st.accEn |-> st.wordIdx <= lastWord);
  p_code_order_r4: assert property (@(posedge clk) disable iff (!rstN)
    st.eccEn |-> st.eccIdx <= lastEcc);
  p_restart_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRst |=> (phase == PH_DATA) && (wordCnt == '0) && (eccCnt == '0));
endmodule

// File: rtl/nand_ecc_datapath.sv
module nand_ecc_datapath
  import nand_ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              bus16,
  input  logic [DATA_W-1:0] dataIn,
  input  ecc_strobe_t       st,
  output logic [ECC_W-1:0]  parityOut,
  output logic [ECC_W-1:0]  nparityOut,
  output logic              recErr,
  output logic              eccErr,
  output logic              mulErr
);
  logic [ECC_W-1:0] accP, accN, eccP, eccN;
  logic [ECC_W-1:0] addP, addN, addr;
  logic [ECC_W-1:0] synP, synN;
  logic [2*ECC_W-1:0] synAll;
  logic nonZero, oneBit;

  always_comb begin
    addP = '0;
    addN = '0;
    addr = '0;
    for (int b = 0; b < DATA_W; b++) begin
      if ((b < 8 || bus16) && dataIn[b]) begin
        addr = {st.wordIdx, BIT_W'(b)};
        addP = addP ^ addr;
        addN = addN ^ ~addr;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accP <= '0; accN <= '0; eccP <= '0; eccN <= '0;
    end else if (st.clr) begin
      accP <= '0; accN <= '0; eccP <= '0; eccN <= '0;
    end else begin
      if (st.accEn) begin
        accP <= accP ^ addP;
        accN <= accN ^ addN;
      end
      if (st.eccEn) begin
        if (bus16) begin
          if (st.eccIdx[0]) eccN <= dataIn;
          else              eccP <= dataIn;
        end else begin
          unique case (st.eccIdx)
            2'd0: eccP[7:0]  <= dataIn[7:0];
            2'd1: eccP[15:8] <= dataIn[7:0];
            2'd2: eccN[7:0]  <= dataIn[7:0];
            default: eccN[15:8] <= dataIn[7:0];
          endcase
        end
      end
    end
  end

  always_comb begin
    synP    = accP ^ eccP;
    synN    = accN ^ eccN;
    synAll  = {synN, synP};
    nonZero = |synAll;
    oneBit  = nonZero && ((synAll & (synAll - 1'b1)) == '0);
    recErr  = st.done && nonZero;
    eccErr  = st.done && oneBit;
    mulErr  = st.done && nonZero && !oneBit && (synP != ~synN);
    parityOut  = st.done ? synP : accP;
    nparityOut = st.done ? synN : accN;
  end

  p_frozen_r10: assert property (@(posedge clk) disable iff (!rstN)
    (st.done && $past(st.done)) |-> ($stable(parityOut) && $stable(nparityOut)));
  p_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    st.clr |=> (accP == '0) && (accN == '0) && (eccP == '0) && (eccN == '0));
  p_exclusive_r12: assert property (@(posedge clk) disable iff (!rstN)
    !(eccErr && mulErr));
  p_implies_r12: assert property (@(posedge clk) disable iff (!rstN)
    (eccErr || mulErr) |-> recErr);
  p_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !st.done |-> !(recErr || eccErr || mulErr));
endmodule

// File: rtl/nand_page_ecc.sv
module nand_page_ecc
  import nand_ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              bus16,
  input  logic [1:0]        pageSel,
  input  logic              ctrlRst,
  input  logic              strobe,
  input  logic [DATA_W-1:0] dataIn,
  output logic [ECC_W-1:0]  parityOut,
  output logic [ECC_W-1:0]  nparityOut,
  output logic              recErr,
  output logic              eccErr,
  output logic              mulErr
);
  ecc_strobe_t st;

  nand_ecc_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .bus16(bus16), .pageSel(pageSel),
    .ctrlRst(ctrlRst), .strobe(strobe), .st(st)
  );

  nand_ecc_datapath dp_i (
    .clk(clk), .rstN(rstN), .bus16(bus16), .dataIn(dataIn), .st(st),
    .parityOut(parityOut), .nparityOut(nparityOut),
    .recErr(recErr), .eccErr(eccErr), .mulErr(mulErr)
  );
endmodule

// File: tb/nand_page_ecc_tb_top.sv
module nand_page_ecc_tb_top;
  logic clk = 0, rstN = 0, bus16 = 0, ctrlRst = 0, strobe = 0;
  logic [1:0] pageSel = 0;
  logic [15:0] dataIn = 0;
  logic [15:0] parityOut, nparityOut;
  logic recErr, eccErr, mulErr;
  int nChecks = 0, nFails = 0;
  logic [15:0] mem [0:4095];
  logic [15:0] refP, refN;

  always #5 clk = ~clk;

  nand_page_ecc dut_i (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkFlags(string req, logic r, logic e, logic m);
    check(req, {29'd0, recErr, eccErr, mulErr}, {29'd0, r, e, m});
  endtask

  function automatic int words(logic w16, logic [1:0] sel);
    return (512 << sel) >> w16;
  endfunction

  task automatic refCalc(int n, logic w16);
    logic [15:0] a;
    refP = 0; refN = 0;
    for (int w = 0; w < n; w++)
      for (int b = 0; b < (w16 ? 16 : 8); b++)
        if (mem[w][b]) begin
          a = {w[11:0], b[3:0]};
          refP ^= a; refN ^= ~a;
        end
  endtask

  task automatic fillRandom(int n, logic w16);
    for (int w = 0; w < n; w++)
      mem[w] = w16 ? 16'($urandom) : {8'h00, 8'($urandom)};
  endtask

  task automatic push(logic [15:0] w);
    @(negedge clk); strobe = 1; dataIn = w;
  endtask

  task automatic idle();
    @(negedge clk); strobe = 0; dataIn = 0;
    @(negedge clk);
  endtask

  task automatic pageReset();
    @(negedge clk); ctrlRst = 1;
    @(negedge clk); ctrlRst = 0;
  endtask

  task automatic sendData(int n);
    for (int w = 0; w < n; w++) push(mem[w]);
  endtask

  task automatic sendCode(logic [15:0] p, logic [15:0] n, logic w16, bit holdLast);
    if (w16) begin push(p); if (!holdLast) push(n); end
    else begin
      push({8'h0, p[7:0]}); push({8'h0, p[15:8]}); push({8'h0, n[7:0]});
      if (!holdLast) push({8'h0, n[15:8]});
    end
  endtask

  // full read of the page in mem with a given stored code
  task automatic readPage(int n, logic w16, logic [15:0] p, logic [15:0] q);
    pageReset(); sendData(n); sendCode(p, q, w16, 0); idle();
  endtask

  task automatic testReset();
    check("R3 reset parity", parityOut, 0);
    check("R3 reset nparity", nparityOut, 0);
    checkFlags("R9 reset flags", 0, 0, 0);
  endtask

  task automatic testAccumulate();
    bus16 = 0; pageSel = 0;
    pageReset(); push(16'h0001); idle();
    check("R2 one bit at word0 parity", parityOut, 16'h0000);
    check("R2 one bit at word0 nparity", nparityOut, 16'hFFFF);
    pageReset(); push(16'h0000); push(16'h0020); idle();
    check("R2 bit5 of word1 parity", parityOut, 16'h0015);
    fillRandom(512, 0); refCalc(512, 0);
    pageReset(); sendData(512); idle();
    check("R2 write parity", parityOut, refP);
    check("R2 write nparity", nparityOut, refN);
    checkFlags("R9 no flags before code", 0, 0, 0);
  endtask

  task automatic testClean();
    pageReset(); sendData(512); sendCode(refP, refN, 0, 1); idle();
    checkFlags("R9 flags low before last code strobe", 0, 0, 0);
    push({8'h0, refN[15:8]}); idle();
    checkFlags("R5 clean flags", 0, 0, 0);
    check("R5 clean syndrome", {parityOut, nparityOut}, 0);
    push(16'h00FF); idle();
    check("R10 ignored after done", {parityOut, nparityOut}, 0);
    checkFlags("R10 flags hold", 0, 0, 0);
    pageReset();
    check("R3 clear after page", {parityOut, nparityOut}, 0);
  endtask

  task automatic testSingleData();
    for (int k = 0; k < 3; k++) begin
      int w = $urandom_range(0, 511);
      int b = $urandom_range(0, 7);
      mem[w][b] = ~mem[w][b];
      readPage(512, 0, refP, refN);
      checkFlags("R6 single data flags", 1, 0, 0);
      check("R6 single data location", parityOut, {w[11:0], b[3:0]});
      mem[w][b] = ~mem[w][b];
    end
  endtask

  task automatic testCodeFlip();
    readPage(512, 0, refP ^ 16'h0100, refN);
    checkFlags("R7 parity code flip", 1, 1, 0);
    readPage(512, 0, refP, refN ^ 16'h0004);
    checkFlags("R7 nparity code flip", 1, 1, 0);
  endtask

  task automatic testDouble();
    mem[3][1] = ~mem[3][1]; mem[400][6] = ~mem[400][6];
    readPage(512, 0, refP, refN);
    checkFlags("R8 two-bit flags", 1, 0, 1);
    mem[3][1] = ~mem[3][1]; mem[400][6] = ~mem[400][6];
  endtask

  task automatic testErased();
    for (int w = 0; w < 512; w++) mem[w] = 16'h00FF;
    readPage(512, 0, 16'hFFFF, 16'hFFFF);
    checkFlags("R8 erased flags", 1, 0, 1);
    check("R8 erased offsets", parityOut, 16'hFFFF);
  endtask

  task automatic testWide();
    bus16 = 1; pageSel = 0;
    fillRandom(256, 1); refCalc(256, 1);
    mem[200][13] = ~mem[200][13];
    readPage(256, 1, refP, refN);
    checkFlags("R11 16-bit single flags", 1, 0, 0);
    check("R11 16-bit location", parityOut, {12'd200, 4'd13});
    mem[200][13] = ~mem[200][13];
    readPage(256, 1, refP, refN);
    checkFlags("R4 16-bit clean", 0, 0, 0);
  endtask

  task automatic testLargerPage();
    bus16 = 0; pageSel = 1;
    fillRandom(words(0, 1), 0); refCalc(words(0, 1), 0);
    mem[1000][2] = ~mem[1000][2];
    readPage(words(0, 1), 0, refP, refN);
    checkFlags("R1 1024-byte page flags", 1, 0, 0);
    check("R1 1024-byte location", parityOut, {12'd1000, 4'd2});
  endtask

  task automatic testMidReset();
    bus16 = 0; pageSel = 0;
    pageReset(); push(16'h0081); push(16'h0042); idle();
    pageReset();
    check("R3 mid-page clear", {parityOut, nparityOut}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testAccumulate();
    testClean();
    testSingleData();
    testCodeFlip();
    testDouble();
    testErased();
    testWide();
    testLargerPage();
    testMidReset();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule